// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

The block sits behind the start-of-frame delimiter detector on the receive path. It takes a byte stream with a valid strobe and an end-of-frame marker, then pulls out the destination address, source address and byte-count field. It counts the frame length, runs a CRC-32 over every byte including the trailing frame check sequence, and forwards the frame to the host. At the end of the frame it reports a status word that flags runt, oversize and CRC-error frames.

A per-frame mode input selects whether the four check-sequence bytes reach the host. When they are withheld, the forwarded stream runs four bytes behind the input. This lets the block drop the check sequence without looking back once the frame ends. When they are kept, each byte is forwarded one cycle after it is accepted.

Top module: `eth_rx_checker`

## Requirements
- R1: Bytes 0..5 of a frame (counting from 0 after the delimiter) form `dst_addr_o`, with byte 0 in bits 47:40. Bytes 6..11 form `src_addr_o` in the same order. Bytes 12..13 form `len_type_o`, with byte 12 in bits 15:8. `fields_valid_o` pulses for one cycle in the cycle after byte 13 is accepted.
- R2: With `keep_fcs_i` = 0, the last four bytes of a frame are not forwarded. Byte k leaves one cycle after byte k+4 is accepted. `out_last_o` marks the final forwarded byte. A frame of four bytes or fewer forwards nothing.
- R3: With `keep_fcs_i` = 1, every byte, the check sequence included, leaves one cycle after it is accepted. `out_last_o` is set on the byte that follows the input end-of-frame.
- R4: The mode is sampled with the first byte of a frame. Changes to `keep_fcs_i` later in the same frame have no effect.
- R5: `status_valid_o` is high for exactly one cycle: the cycle after a byte with `in_last_i` is accepted. It is never high at any other time, and back-to-back frames are reported separately.
- R6: A frame of fewer than 64 bytes (check sequence included) sets `status_runt_o`. A frame of exactly 64 bytes does not.
- R7: A frame of more than 1518 bytes sets `status_oversize_o`. A frame of exactly 1518 bytes does not. Runt and oversize are never set together.
- R8: The CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones) runs over the whole frame. `status_crc_err_o` is set unless the bit-reversed register equals 0xC704DD7B. `status_good_o` is set only when runt, oversize and CRC error are all clear.
- R9: Cycles with `in_valid_i` low inside a frame change no field, count, CRC or output.
- R10: After reset, all valid, last and status outputs are low and the address and byte-count fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte is the last of the frame |
| keep_fcs_i | input | 1 | 1: forward the check sequence; 0: withhold it |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_data_o | output | 8 | Forwarded byte |
| out_last_o | output | 1 | Last forwarded byte of the frame |
| dst_addr_o | output | 48 | Destination address |
| src_addr_o | output | 48 | Source address |
| len_type_o | output | 16 | Byte-count field |
| fields_valid_o | output | 1 | Address and byte-count fields just completed |
| status_valid_o | output | 1 | Status word valid |
| status_good_o | output | 1 | Frame good |
| status_runt_o | output | 1 | Frame shorter than minimum |
| status_oversize_o | output | 1 | Frame longer than maximum |
| status_crc_err_o | output | 1 | CRC residue mismatch |

## Verification
The status pulse for one frame and the first byte of the next frame fall on the same clock edge when frames arrive back to back. In that cycle the counter, CRC register, mode latch and delay line must all be re-armed while the finished frame's verdict is registered. The bench chains a 70-byte frame directly into a 64-byte frame with no idle cycle. It checks that two separate, correct status words appear, that both sets of fields are captured, and that the forwarded bytes of the two frames do not mix. The final forwarded byte and the status pulse also share a cycle; the bench compares the pulse timing against the input end-of-frame on every cycle.

// File: rtl/eth_rx_pkg.sv
`timescale 1ns/1ps
package eth_rx_pkg;

  typedef struct packed {
    logic good;
    logic runt;
    logic oversize;
    logic crc_err;
  } rx_status_t;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] bit_rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/eth_rx_crc.sv
`timescale 1ns/1ps
module eth_rx_crc #(
  parameter logic [31:0] RESIDUE = 32'hC704_DD7B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       last_i,
  input  logic [7:0] data_i,
  output logic       ok_o
);
  import eth_rx_pkg::*;

  logic [31:0] crc_q, crc_nxt;

  assign crc_nxt = crc32_step(crc_q, data_i);
  assign ok_o    = (bit_rev32(crc_nxt) == RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (valid_i) crc_q <= last_i ? '1 : crc_nxt;
  end
endmodule

// File: rtl/eth_rx_delay.sv
`timescale 1ns/1ps
module eth_rx_delay #(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       last_i,
  input  logic [7:0] data_i,
  output logic       full_o,
  output logic [7:0] tail_o
);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(DEPTH);

  logic [7:0]    stage_q [DEPTH];
  logic [FW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q[0] <= '0;
    else if (valid_i) stage_q[0] <= data_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[g] <= '0;
      else if (valid_i) stage_q[g] <= stage_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (valid_i) begin
      if (last_i)                 fill_q <= '0;
      else if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign full_o = (fill_q == FILL_MAX);
  assign tail_o = stage_q[DEPTH-1];
endmodule

// File: rtl/eth_rx_fields.sv
`timescale 1ns/1ps
module eth_rx_fields #(
  parameter int IDX_W      = 11,
  parameter int ADDR_BYTES = 6,
  parameter int LEN_BYTES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [7:0]              data_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [8*ADDR_BYTES-1:0] dst_o,
  output logic [8*ADDR_BYTES-1:0] src_o,
  output logic [8*LEN_BYTES-1:0]  len_o,
  output logic                    done_o
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int LW = 8 * LEN_BYTES;
  localparam logic [IDX_W-1:0] SRC_AT  = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LEN_AT  = IDX_W'(2 * ADDR_BYTES);
  localparam logic [IDX_W-1:0] END_AT  = IDX_W'(2 * ADDR_BYTES + LEN_BYTES);
  localparam logic [IDX_W-1:0] LAST_AT = IDX_W'(2 * ADDR_BYTES + LEN_BYTES - 1);

  logic [AW-1:0] dst_q, src_q;
  logic [LW-1:0] len_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q  <= '0;
      src_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i && (idx_i == LAST_AT);
      if (valid_i) begin
        if (idx_i < SRC_AT)      dst_q <= {dst_q[AW-9:0], data_i};
        else if (idx_i < LEN_AT) src_q <= {src_q[AW-9:0], data_i};
        else if (idx_i < END_AT) len_q <= {len_q[LW-9:0], data_i};
      end
    end
  end

  assign dst_o  = dst_q;
  assign src_o  = src_q;
  assign len_o  = len_q;
  assign done_o = done_q;
endmodule

// File: rtl/eth_rx_checker.sv
`timescale 1ns/1ps
module eth_rx_checker #(
  parameter int          MIN_LEN    = 64,
  parameter int          MAX_LEN    = 1518,
  parameter int          FCS_BYTES  = 4,
  parameter int          ADDR_BYTES = 6,
  parameter int          LEN_BYTES  = 2,
  parameter logic [31:0] RESIDUE    = 32'hC704_DD7B
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [7:0]              in_data_i,
  input  logic                    in_last_i,
  input  logic                    keep_fcs_i,
  output logic                    out_valid_o,
  output logic [7:0]              out_data_o,
  output logic                    out_last_o,
  output logic [8*ADDR_BYTES-1:0] dst_addr_o,
  output logic [8*ADDR_BYTES-1:0] src_addr_o,
  output logic [8*LEN_BYTES-1:0]  len_type_o,
  output logic                    fields_valid_o,
  output logic                    status_valid_o,
  output logic                    status_good_o,
  output logic                    status_runt_o,
  output logic                    status_oversize_o,
  output logic                    status_crc_err_o
);
  import eth_rx_pkg::*;

  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEN);

  logic             in_frame_q, keep_q, keep_eff, sof;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             crc_ok, tail_full;
  logic [7:0]       tail_byte;
  logic             out_valid_q, out_last_q, stat_valid_q;
  logic [7:0]       out_data_q;
  rx_status_t       stat_q, stat_nxt;
  logic             fwd;

  assign sof      = !in_frame_q;
  assign keep_eff = sof ? keep_fcs_i : keep_q;
  assign cnt_nxt  = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
  assign fwd      = in_valid_i && (keep_eff || tail_full);

  always_comb begin
    stat_nxt.runt     = (cnt_nxt < CNT_MIN);
    stat_nxt.oversize = (cnt_nxt > CNT_MAX);
    stat_nxt.crc_err  = !crc_ok;
    stat_nxt.good     = !(stat_nxt.runt || stat_nxt.oversize || stat_nxt.crc_err);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      cnt_q      <= '0;
    end else if (in_valid_i) begin
      in_frame_q <= !in_last_i;
      if (sof) keep_q <= keep_fcs_i;
      cnt_q <= in_last_i ? '0 : cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q  <= 1'b0;
      out_last_q   <= 1'b0;
      out_data_q   <= '0;
      stat_valid_q <= 1'b0;
      stat_q       <= '0;
    end else begin
      out_valid_q  <= fwd;
      out_last_q   <= fwd && in_last_i;
      if (fwd) out_data_q <= keep_eff ? in_data_i : tail_byte;
      stat_valid_q <= in_valid_i && in_last_i;
      if (in_valid_i && in_last_i) stat_q <= stat_nxt;
    end
  end

  eth_rx_crc #(.RESIDUE(RESIDUE)) u_crc (
    .clk_i, .rst_ni,
    .valid_i (in_valid_i),
    .last_i  (in_last_i),
    .data_i  (in_data_i),
    .ok_o    (crc_ok)
  );

  eth_rx_delay #(.DEPTH(FCS_BYTES)) u_delay (
    .clk_i, .rst_ni,
    .valid_i (in_valid_i),
    .last_i  (in_last_i),
    .data_i  (in_data_i),
    .full_o  (tail_full),
    .tail_o  (tail_byte)
  );

  eth_rx_fields #(.IDX_W(CNT_W), .ADDR_BYTES(ADDR_BYTES), .LEN_BYTES(LEN_BYTES)) u_fields (
    .clk_i, .rst_ni,
    .valid_i (in_valid_i),
    .data_i  (in_data_i),
    .idx_i   (cnt_q),
    .dst_o   (dst_addr_o),
    .src_o   (src_addr_o),
    .len_o   (len_type_o),
    .done_o  (fields_valid_o)
  );

  assign out_valid_o       = out_valid_q;
  assign out_data_o        = out_data_q;
  assign out_last_o        = out_last_q;
  assign status_valid_o    = stat_valid_q;
  assign status_good_o     = stat_q.good;
  assign status_runt_o     = stat_q.runt;
  assign status_oversize_o = stat_q.oversize;
  assign status_crc_err_o  = stat_q.crc_err;
endmodule

// File: rtl/eth_rx_checker_sva.sv
`timescale 1ns/1ps
module eth_rx_checker_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_last_i,
  input logic out_valid_o,
  input logic out_last_o,
  input logic fields_valid_o,
  input logic status_valid_o,
  input logic status_runt_o,
  input logic status_oversize_o
);
  p_status_follows_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i) |=> status_valid_o);

  p_status_only_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> $past(in_valid_i && in_last_i));

  p_out_needs_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  p_last_with_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (status_valid_o && out_valid_o));

  p_fields_needs_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fields_valid_o |-> $past(in_valid_i));

  p_runt_long_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_valid_o |-> !(status_runt_o && status_oversize_o));
endmodule

bind eth_rx_checker eth_rx_checker_sva u_sva (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .in_valid_i        (in_valid_i),
  .in_last_i         (in_last_i),
  .out_valid_o       (out_valid_o),
  .out_last_o        (out_last_o),
  .fields_valid_o    (fields_valid_o),
  .status_valid_o    (status_valid_o),
  .status_runt_o     (status_runt_o),
  .status_oversize_o (status_oversize_o)
);

// File: tb/eth_rx_checker_tb.sv
`timescale 1ns/1ps
module eth_rx_checker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_last = 0, keep_fcs = 0;
  logic [7:0]  in_data = 0;
  logic        out_valid, out_last, fields_valid;
  logic [7:0]  out_data;
  logic [47:0] dst, src;
  logic [15:0] len_type;
  logic        st_valid, st_good, st_runt, st_long, st_crc;

  eth_rx_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .keep_fcs_i(keep_fcs),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .dst_addr_o(dst), .src_addr_o(src), .len_type_o(len_type), .fields_valid_o(fields_valid),
    .status_valid_o(st_valid), .status_good_o(st_good), .status_runt_o(st_runt),
    .status_oversize_o(st_long), .status_crc_err_o(st_crc)
  );

  int tests = 0, fails = 0;
  logic [7:0]  tx_buf [0:3199];
  logic [7:0]  rx_buf [0:3199];
  int          rx_n, rx_last_at, last_cnt, st_n, f_n;
  logic [3:0]  st_log [0:7];
  logic [47:0] fd_log [0:7];
  logic [47:0] fs_log [0:7];
  logic [15:0] fl_log [0:7];
  logic        pend_last = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // timing model of R5: status exactly one cycle after an accepted last byte
  always @(posedge clk) pend_last <= rst_n && in_valid && in_last;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (rx_n < 3200) rx_buf[rx_n] = out_data;
      rx_n++;
      if (out_last) begin rx_last_at = rx_n - 1; last_cnt++; end
    end
    if (st_valid || pend_last) chk(st_valid == pend_last, "R5 status timing", st_valid, pend_last);
    if (st_valid && st_n < 8) begin st_log[st_n] = {st_good, st_runt, st_long, st_crc}; st_n++; end
    if (fields_valid && f_n < 8) begin
      fd_log[f_n] = dst; fs_log[f_n] = src; fl_log[f_n] = len_type; f_n++;
    end
  end

  function automatic logic [31:0] crc_add(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ d[b];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic bit frame_crc_ok(int toff, int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) c = crc_add(c, tx_buf[toff+i]);
    return c == 32'hDEBB20E3;
  endfunction

  task automatic build_frame(int toff, int n, int seed, bit bad);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) tx_buf[toff+i] = 8'((i * 13 + seed * 29 + (i >> 3)) & 255);
    if (n >= 4) begin
      for (int i = 0; i < n - 4; i++) c = crc_add(c, tx_buf[toff+i]);
      c = ~c;
      for (int j = 0; j < 4; j++) tx_buf[toff+n-4+j] = c[8*j +: 8];
    end
    if (bad) tx_buf[toff + n/2] = tx_buf[toff + n/2] ^ 8'h10;
  endtask

  task automatic clear_logs();
    rx_n = 0; rx_last_at = -1; last_cnt = 0; st_n = 0; f_n = 0;
  endtask

  task automatic drive_frame(int toff, int n, bit keep, bit gap, bit flip, bit chain);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = tx_buf[toff+i]; in_last = (i == n - 1);
      keep_fcs = (flip && i > 0) ? !keep : keep;
      @(posedge clk); #1;
      if (gap && (i % 5 == 2) && i != n - 1) begin
        in_valid = 0; in_data = 8'hA5; in_last = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
      end
    end
    if (!chain) begin in_valid = 0; in_last = 0; end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic expect_frame(int toff, int n, bit keep, int roff, int idx, string req);
    int nout, bad;
    logic [47:0] ed = '0, es = '0;
    logic [15:0] el;
    bit runt, lng, crc;
    nout = keep ? n : ((n > 4) ? n - 4 : 0);
    bad = 0;
    for (int i = 0; i < nout; i++) if (rx_buf[roff+i] !== tx_buf[toff+i]) bad++;
    chk(bad == 0, keep ? "R3 forwarded bytes" : "R2 forwarded bytes", bad, 0);
    runt = n < 64; lng = n > 1518; crc = !frame_crc_ok(toff, n);
    chk(st_log[idx] == {!(runt || lng || crc), runt, lng, crc},
        {req, " status {good,runt,oversize,crc_err}"}, st_log[idx],
        {!(runt || lng || crc), runt, lng, crc});
    if (n >= 14) begin
      for (int i = 0; i < 6; i++) begin
        ed = {ed[39:0], tx_buf[toff+i]};
        es = {es[39:0], tx_buf[toff+6+i]};
      end
      el = {tx_buf[toff+12], tx_buf[toff+13]};
      chk(fd_log[idx] == ed, "R1 dst", fd_log[idx], ed);
      chk(fs_log[idx] == es, "R1 src", fs_log[idx], es);
      chk(fl_log[idx] == el, "R1 len", fl_log[idx], el);
    end
  endtask

  task automatic run_one(int n, int seed, bit keep, bit bad, bit gap, bit flip, string req);
    int nout;
    clear_logs();
    build_frame(0, n, seed, bad);
    drive_frame(0, n, keep, gap, flip, 0);
    settle();
    nout = keep ? n : ((n > 4) ? n - 4 : 0);
    chk(st_n == 1, "R5 one status per frame", st_n, 1);
    chk(f_n == ((n >= 14) ? 1 : 0), "R1 fields pulse count", f_n, (n >= 14) ? 1 : 0);
    chk(rx_n == nout, {req, " output byte count"}, rx_n, nout);
    if (nout > 0) chk(rx_last_at == nout - 1 && last_cnt == 1, "R2/R3 out_last position", rx_last_at, nout - 1);
    else          chk(last_cnt == 0, "R2 no out_last on tiny frame", last_cnt, 0);
    expect_frame(0, n, keep, 0, 0, req);
  endtask

  task automatic t_reset();
    #1;
    chk({out_valid, out_last, st_valid, fields_valid} == 4'b0, "R10 valids in reset",
        {out_valid, out_last, st_valid, fields_valid}, 0);
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({out_valid, out_last, st_valid, fields_valid} == 4'b0, "R10 valids after reset",
        {out_valid, out_last, st_valid, fields_valid}, 0);
    chk(dst == 0 && src == 0 && len_type == 0, "R10 fields zero", dst ^ src, 0);
  endtask

  task automatic t_min_strip();   run_one(64,   1, 0, 0, 0, 0, "R6 R8 min good strip"); endtask
  task automatic t_keep();        run_one(100,  2, 1, 0, 0, 0, "R3 keep mode");         endtask
  task automatic t_max();         run_one(1518, 3, 0, 0, 0, 0, "R7 max good");          endtask
  task automatic t_oversize();    run_one(1519, 4, 0, 0, 0, 0, "R7 oversize");          endtask
  task automatic t_runt();        run_one(63,   5, 0, 0, 0, 0, "R6 runt");              endtask
  task automatic t_tiny();        run_one(3,    6, 0, 0, 0, 0, "R2 tiny strip");        endtask
  task automatic t_bad_crc();     run_one(80,   7, 0, 1, 0, 0, "R8 crc error");         endtask
  task automatic t_mode_change(); run_one(70,   8, 1, 0, 0, 1, "R4 mode held");         endtask
  task automatic t_mode_change2();run_one(70,   9, 0, 0, 0, 1, "R4 mode held strip");   endtask
  task automatic t_gaps();        run_one(90,  10, 0, 0, 1, 0, "R9 idle gaps");         endtask

  task automatic t_back_to_back();
    clear_logs();
    build_frame(0, 70, 11, 0);
    build_frame(1600, 64, 12, 1);
    drive_frame(0, 70, 0, 0, 0, 1);
    drive_frame(1600, 64, 0, 0, 0, 0);
    settle();
    chk(st_n == 2, "R5 back-to-back status count", st_n, 2);
    chk(f_n == 2, "R1 back-to-back fields count", f_n, 2);
    chk(rx_n == 126 && last_cnt == 2, "R2 back-to-back byte count", rx_n, 126);
    expect_frame(0, 70, 0, 0, 0, "R5 first of pair");
    expect_frame(1600, 64, 0, 66, 1, "R5 second of pair");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk); #1;
    t_min_strip();
    t_keep();
    t_max();
    t_oversize();
    t_runt();
    t_tiny();
    t_bad_crc();
    t_mode_change();
    t_mode_change2();
    t_gaps();
    t_back_to_back();
    summary();
    $finish;
  end
endmodule